// File: doc/BRIEF.md
# I2C Mode and Status Controller

This block owns the operating mode of an I2C controller and the status flags software polls. The mode is two bits: master/slave and transmit/receive. The flags are bus-busy, interrupt-pending, arbitration-lost, address-matched, general-call and last received bit. A separate bit-level engine reports bus activity as single-cycle event pulses, and the block turns those pulses into mode and flag updates. These events are START seen, STOP seen, arbitration lost, byte complete, address phase complete and missing acknowledge.

Software writes the status byte through a one-cycle write strobe. Only the two mode bits and the start request are writable. A write that sets the mode bits and the bus-busy bit together while the bus is idle claims the bus: master, transmit and busy all become set on the same clock edge.

A collision window protects against two masters starting at almost the same moment. The window opens when bus-busy rises and closes when the address phase completes. A software write that lands inside the window is refused, and the refusal forces both mode bits to 0. When a hardware event clears a bit in the same cycle that software sets it, the hardware clear takes effect.

Top module: `i2c_mode_stat`

## Requirements
- R1: After reset is asserted, `stat_o` reads 8'h00 and `mode_o` reads 2'b00.
- R2: `stat_o` bit layout: [7] master, [6] transmit, [5] bus busy, [4] pending, [3] arbitration lost, [2] address matched, [1] general call, [0] last bit. `mode_o` = {master, transmit}, where 00 is slave receive, 01 slave transmit, 10 master receive and 11 master transmit. An accepted write copies wdata[7:6] into master/transmit on the next edge. Write data in bits [4:0], and in bit 5 (except as R3 and R5 describe), has no effect.
- R3: A write whose bits [7:5] are 3'b111, made while bus busy is 0, sets master, transmit and bus busy together on the next edge, and clears the arbitration-lost flag.
- R4: `start_det_i` sets bus busy and `stop_det_i` clears it, for STARTs and STOPs from any master.
- R5: A write is refused when the collision window is open, or when it coincides with `start_det_i`, or when wdata[5]=1 while bus busy is already 1. A refused write clears master and transmit.
- R6: The collision window opens when bus busy rises and closes on `addr_done_i` or on `stop_det_i`.
- R7: On `addr_done_i`, transmit is set to 1 only when master=0, `raw_fmt_i`=0 and `rw_bit_i`=1.
- R8: Transmit clears on `arb_lost_i`. It also clears on `start_det_i` or `nack_i` while master=0.
- R9: `arb_lost_i` sets the arbitration-lost flag but leaves master set. Master clears on the next `byte_done_i`, or on the same cycle if byte completion coincides with the loss.
- R10: `stop_det_i` clears master, transmit and bus busy, and closes the collision window.
- R11: A hardware clear and a software set reaching the same bit in one cycle leave the bit at 0.
- R12: `addr_done_i` with `addr_match_i` or `gen_call_i` sets the matching flag; `start_det_i` or `stop_det_i` clears both. `byte_done_i` captures `last_bit_i` and sets pending. `irq_clr_i` clears pending, but a simultaneous `byte_done_i` keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Software write strobe, one cycle |
| sw_wdata_i | input | 8 | Software write data in status layout |
| raw_fmt_i | input | 1 | 1 = data without address format (blocks hardware transmit set) |
| start_det_i | input | 1 | START detected pulse |
| stop_det_i | input | 1 | STOP detected pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| byte_done_i | input | 1 | Byte complete pulse |
| last_bit_i | input | 1 | Last received bit, valid with byte_done_i |
| addr_done_i | input | 1 | Address phase complete pulse |
| addr_match_i | input | 1 | Own address matched, valid with addr_done_i |
| gen_call_i | input | 1 | General call address, valid with addr_done_i |
| rw_bit_i | input | 1 | Received R/W bit, valid with addr_done_i |
| nack_i | input | 1 | Acknowledge missing pulse |
| irq_clr_i | input | 1 | Clear pending flag pulse |
| stat_o | output | 8 | Status byte |
| mode_o | output | 2 | Current mode {master, transmit} |

## Verification
Every result is a single register stage behind its cause. An event or write sampled on one rising edge is visible on `stat_o` right after that edge. The exception is the delayed master clear after a lost arbitration, which waits for the later byte-complete pulse.

The bench changes inputs on the falling edge and lowers them on the next falling edge. It reads `stat_o` only at that point, so exactly one update edge lies between stimulus and check. The deferred clear is checked twice: once after the loss, where master must still be 1, and once after byte completion, where it must be 0.

// File: rtl/i2c_ms_pkg.sv
package i2c_ms_pkg;
  localparam int STAT_W = 8;

  // bit positions inside the status byte; software decodes these
  localparam int B_MST  = 7;
  localparam int B_TRX  = 6;
  localparam int B_BB   = 5;
  localparam int B_PEND = 4;
  localparam int B_ARBL = 3;
  localparam int B_AAS  = 2;
  localparam int B_GCAL = 1;
  localparam int B_LAST = 0;

  localparam int N_ADDR_FLAGS = 2;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;

  typedef struct packed {
    logic pend;
    logic arbl;
    logic aas;
    logic gcal;
    logic last;
  } flags_t;
endpackage

// File: rtl/i2c_busy_guard.sv
module i2c_busy_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic addr_done_i,
  input  logic sw_start_i,
  output logic bb_o,
  output logic guard_o
);
  logic bb_q, guard_q;
  logic raise;

  assign raise = start_det_i | sw_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bb_q    <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      if (stop_det_i) begin
        bb_q    <= 1'b0;
        guard_q <= 1'b0;
      end else begin
        if (raise) bb_q <= 1'b1;
        // window opens only on a rising busy flag
        if (!bb_q && raise) guard_q <= 1'b1;
        else if (addr_done_i) guard_q <= 1'b0;
      end
    end
  end

  assign bb_o    = bb_q;
  assign guard_o = guard_q;
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_hit_i,
  input  logic sw_reject_i,
  input  logic sw_mst_i,
  input  logic sw_trx_i,
  input  logic raw_fmt_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  input  logic byte_done_i,
  input  logic addr_done_i,
  input  logic rw_bit_i,
  input  logic nack_i,
  output logic mst_o,
  output logic trx_o
);
  logic mst_q, trx_q, arm_q;
  logic mst_d, trx_d, arm_d;
  logic mst_clr, trx_clr, trx_hw_set;

  assign trx_hw_set = addr_done_i & ~mst_q & ~raw_fmt_i & rw_bit_i;

  assign trx_clr = sw_reject_i | stop_det_i | arb_lost_i
                 | (~mst_q & (start_det_i | nack_i));

  // master drops at the end of the byte in which arbitration was lost
  assign mst_clr = sw_reject_i | stop_det_i
                 | (byte_done_i & (arm_q | arb_lost_i));

  always_comb begin
    mst_d = mst_q;
    trx_d = trx_q;
    arm_d = arm_q;
    if (sw_hit_i) begin
      mst_d = sw_mst_i;
      trx_d = sw_trx_i;
    end
    if (trx_hw_set) trx_d = 1'b1;
    // hardware clears win over any set
    if (trx_clr) trx_d = 1'b0;
    if (mst_clr) mst_d = 1'b0;
    if (arb_lost_i) arm_d = 1'b1;
    if (byte_done_i || stop_det_i) arm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q <= 1'b0;
      trx_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      mst_q <= mst_d;
      trx_q <= trx_d;
      arm_q <= arm_d;
    end
  end

  assign mst_o = mst_q;
  assign trx_o = trx_q;
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
  import i2c_ms_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_det_i,
  input  logic   stop_det_i,
  input  logic   arb_lost_i,
  input  logic   sw_start_i,
  input  logic   byte_done_i,
  input  logic   last_bit_i,
  input  logic   addr_done_i,
  input  logic   addr_match_i,
  input  logic   gen_call_i,
  input  logic   irq_clr_i,
  output flags_t flags_o
);
  logic [N_ADDR_FLAGS-1:0] addr_src;
  logic [N_ADDR_FLAGS-1:0] addr_q;
  logic pend_q, arbl_q, last_q;

  assign addr_src = {addr_match_i, gen_call_i};

  // address-phase flags share one set/clear pattern
  for (genvar g = 0; g < N_ADDR_FLAGS; g++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         addr_q[g] <= 1'b0;
      else if (start_det_i || stop_det_i)  addr_q[g] <= 1'b0;
      else if (addr_done_i && addr_src[g]) addr_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      arbl_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (byte_done_i)    pend_q <= 1'b1;
      else if (irq_clr_i) pend_q <= 1'b0;
      if (arb_lost_i)      arbl_q <= 1'b1;
      else if (sw_start_i) arbl_q <= 1'b0;
      if (byte_done_i) last_q <= last_bit_i;
    end
  end

  assign flags_o.pend = pend_q;
  assign flags_o.arbl = arbl_q;
  assign flags_o.aas  = addr_q[1];
  assign flags_o.gcal = addr_q[0];
  assign flags_o.last = last_q;
endmodule

// File: rtl/i2c_mode_stat.sv
module i2c_mode_stat
  import i2c_ms_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [STAT_W-1:0] sw_wdata_i,
  input  logic              raw_fmt_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              arb_lost_i,
  input  logic              byte_done_i,
  input  logic              last_bit_i,
  input  logic              addr_done_i,
  input  logic              addr_match_i,
  input  logic              gen_call_i,
  input  logic              rw_bit_i,
  input  logic              nack_i,
  input  logic              irq_clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [1:0]        mode_o
);
  logic   bb, guard, mst, trx;
  logic   sw_hit, sw_reject, sw_start;
  flags_t flags;
  mode_e  cur_mode;
  logic   unused_wdata;

  assign unused_wdata = ^sw_wdata_i[B_PEND:0];

  assign sw_reject = sw_we_i & (guard | start_det_i | (sw_wdata_i[B_BB] & bb));
  assign sw_hit    = sw_we_i & ~sw_reject;
  assign sw_start  = sw_hit & sw_wdata_i[B_MST] & sw_wdata_i[B_TRX] & sw_wdata_i[B_BB];

  i2c_busy_guard u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .addr_done_i (addr_done_i),
    .sw_start_i  (sw_start),
    .bb_o        (bb),
    .guard_o     (guard)
  );

  i2c_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_hit_i    (sw_hit),
    .sw_reject_i (sw_reject),
    .sw_mst_i    (sw_wdata_i[B_MST]),
    .sw_trx_i    (sw_wdata_i[B_TRX]),
    .raw_fmt_i   (raw_fmt_i),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .arb_lost_i  (arb_lost_i),
    .byte_done_i (byte_done_i),
    .addr_done_i (addr_done_i),
    .rw_bit_i    (rw_bit_i),
    .nack_i      (nack_i),
    .mst_o       (mst),
    .trx_o       (trx)
  );

  i2c_flag_regs u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_det_i  (start_det_i),
    .stop_det_i   (stop_det_i),
    .arb_lost_i   (arb_lost_i),
    .sw_start_i   (sw_start),
    .byte_done_i  (byte_done_i),
    .last_bit_i   (last_bit_i),
    .addr_done_i  (addr_done_i),
    .addr_match_i (addr_match_i),
    .gen_call_i   (gen_call_i),
    .irq_clr_i    (irq_clr_i),
    .flags_o      (flags)
  );

  assign cur_mode = mode_e'({mst, trx});
  assign mode_o   = cur_mode;

  always_comb begin
    stat_o         = '0;
    stat_o[B_MST]  = mst;
    stat_o[B_TRX]  = trx;
    stat_o[B_BB]   = bb;
    stat_o[B_PEND] = flags.pend;
    stat_o[B_ARBL] = flags.arbl;
    stat_o[B_AAS]  = flags.aas;
    stat_o[B_GCAL] = flags.gcal;
    stat_o[B_LAST] = flags.last;
  end
endmodule

// File: rtl/i2c_mode_stat_chk.sv
module i2c_mode_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_we_i,
  input logic [7:0] sw_wdata_i,
  input logic       start_det_i,
  input logic       stop_det_i,
  input logic       arb_lost_i,
  input logic       byte_done_i,
  input logic       nack_i,
  input logic [7:0] stat_o
);
  assert_stop_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> (stat_o[7:5] == 3'b000));

  assert_start_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i && !stop_det_i) |=> stat_o[5]);

  assert_arb_trx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> !stat_o[6]);

  assert_arb_keeps_mst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[7] && arb_lost_i && !byte_done_i && !stop_det_i && !sw_we_i) |=> stat_o[7]);

  assert_coincident_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && start_det_i) |=> (stat_o[7:6] == 2'b00));

  assert_start_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_wdata_i[7:5] == 3'b111 && !stat_o[5] && !start_det_i
     && !stop_det_i && !arb_lost_i && !nack_i && !byte_done_i)
    |=> (stat_o[7:5] == 3'b111 && !stat_o[3]));
endmodule

bind i2c_mode_stat i2c_mode_stat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_we_i     (sw_we_i),
  .sw_wdata_i  (sw_wdata_i),
  .start_det_i (start_det_i),
  .stop_det_i  (stop_det_i),
  .arb_lost_i  (arb_lost_i),
  .byte_done_i (byte_done_i),
  .nack_i      (nack_i),
  .stat_o      (stat_o)
);

// File: tb/tb_i2c_mode_stat.sv
module tb_i2c_mode_stat;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sw_we_i = 1'b0;
  logic [7:0] sw_wdata_i = '0;
  logic       raw_fmt_i = 1'b0;
  logic       start_det_i = 1'b0, stop_det_i = 1'b0, arb_lost_i = 1'b0;
  logic       byte_done_i = 1'b0, last_bit_i = 1'b0, addr_done_i = 1'b0;
  logic       addr_match_i = 1'b0, gen_call_i = 1'b0, rw_bit_i = 1'b0;
  logic       nack_i = 1'b0, irq_clr_i = 1'b0;
  logic [7:0] stat_o;
  logic [1:0] mode_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_mode_stat dut (.*);

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (stat_o !== exp) begin
      n_fail++;
      $display("FAIL %s stat actual=%02h expected=%02h", req, stat_o, exp);
    end
  endtask

  task automatic release_all();
    sw_we_i = 0; start_det_i = 0; stop_det_i = 0; arb_lost_i = 0;
    byte_done_i = 0; addr_done_i = 0; nack_i = 0; irq_clr_i = 0;
  endtask

  // inputs held for one edge; check sits right after it
  task automatic step();
    @(negedge clk_i);
    release_all();
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); sw_we_i = 1; sw_wdata_i = d; step();
  endtask

  task automatic stop_pulse();
    @(negedge clk_i); stop_det_i = 1; step();
  endtask

  task automatic start_pulse();
    @(negedge clk_i); start_det_i = 1; step();
  endtask

  task automatic addr_pulse(input logic m, input logic g, input logic rw);
    @(negedge clk_i); addr_done_i = 1; addr_match_i = m; gen_call_i = g; rw_bit_i = rw; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 8'h00);
    n_chk++;
    if (mode_o !== 2'b00) begin n_fail++; $display("FAIL R1 mode actual=%0b expected=00", mode_o); end
    rst_ni = 1'b1;

    // R2/R3: sweep every write value on an idle bus
    for (int w = 0; w < 256; w++) begin
      logic [7:0] d, e;
      d = 8'(w);
      e = (d[7:5] == 3'b111) ? 8'hE0 : {d[7:6], 6'b0};
      wr(d);
      check((d[7:5] == 3'b111) ? "R3" : "R2", e);
      n_chk++;
      if (mode_o !== d[7:6]) begin n_fail++; $display("FAIL R2 mode actual=%0b expected=%0b", mode_o, d[7:6]); end
      stop_pulse();
      check("R10", 8'h00);
    end

    // R7: hardware transmit set over master/format/rw combos
    for (int c = 0; c < 8; c++) begin
      logic m, rf, rw;
      {m, rf, rw} = 3'(c);
      raw_fmt_i = rf;
      wr({m, 7'b0});
      addr_pulse(1'b0, 1'b0, rw);
      check("R7", {m, (~m & ~rf & rw), 6'b0});
      stop_pulse();
      raw_fmt_i = 1'b0;
    end

    // R4/R5/R6: collision window
    start_pulse();             check("R4", 8'h20);
    wr(8'hC0);                 check("R5", 8'h20);
    addr_pulse(1'b0, 1'b0, 1'b0); check("R6", 8'h20);
    wr(8'hC0);                 check("R6", 8'hE0);
    wr(8'hE0);                 check("R5", 8'h20);
    stop_pulse();              check("R4", 8'h00);

    // R5: write coincident with another master's START
    @(negedge clk_i); sw_we_i = 1; sw_wdata_i = 8'hE0; start_det_i = 1; step();
    check("R5", 8'h20);
    stop_pulse();

    // R9/R12: arbitration loss as master
    wr(8'hE0);                 check("R3", 8'hE0);
    addr_pulse(1'b0, 1'b0, 1'b0); check("R6", 8'hE0);
    @(negedge clk_i); arb_lost_i = 1; step();
    check("R9", 8'hA8);
    @(negedge clk_i); byte_done_i = 1; last_bit_i = 1; step();
    check("R9", 8'h39);
    @(negedge clk_i); irq_clr_i = 1; step();
    check("R12", 8'h29);
    @(negedge clk_i); irq_clr_i = 1; byte_done_i = 1; last_bit_i = 0; step();
    check("R12", 8'h38);
    stop_pulse();              check("R10", 8'h18);
    wr(8'hE0);                 check("R3", 8'hF0);
    stop_pulse();
    @(negedge clk_i); irq_clr_i = 1; step();
    check("R12", 8'h00);

    // R8/R12: addressed slave
    start_pulse();             check("R4", 8'h20);
    addr_pulse(1'b1, 1'b0, 1'b1); check("R7", 8'h64);
    @(negedge clk_i); nack_i = 1; step();
    check("R8", 8'h24);
    addr_pulse(1'b0, 1'b1, 1'b1); check("R12", 8'h66);
    start_pulse();             check("R8", 8'h20);
    addr_pulse(1'b1, 1'b1, 1'b0); check("R12", 8'h26);
    stop_pulse();              check("R12", 8'h00);

    // R11: hardware clear beats a same-cycle software set
    @(negedge clk_i); sw_we_i = 1; sw_wdata_i = 8'hC0; stop_det_i = 1; step();
    check("R11", 8'h00);
    wr(8'h40);
    @(negedge clk_i); sw_we_i = 1; sw_wdata_i = 8'h40; arb_lost_i = 1; step();
    check("R11", 8'h08);
    wr(8'hE0);                 check("R3", 8'hE0);
    stop_pulse();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule